// File: doc/BRIEF.md
# Cache Tag Store with Qualified Comparator

This block keeps the tag directory of a secondary cache. Each line address owns one tag word and three status flags. A lookup presents a line address and the tag of the current bus address. The block compares that tag with the stored tag at that line and raises a hit output. In the fixed status mode the hit is qualified by the stored valid flag. Reads of the stored tag and status, the comparison and the hit are combinational from the inputs. Updates of the array happen only on a rising clock edge.

The tag field and the status field each have their own write enable, so a controller can rewrite one field without touching the other. A clocked active-low flush clears every status flag in the array at once, which invalidates all lines in one cycle. A mode input selects what the status flags mean. They are either fixed valid/dirty/write-through flags that the block uses itself, or plain user storage with no effect inside the block. Two chip selects gate every access. Separate output enables gate the tag read data, the status read data and the transfer-acknowledge output. The transfer acknowledge is built from the hit, the stored flags, the bus direction, an external acknowledge and a force-off input.

Top module: `ctag_store`

## Requirements
- R1: A tag write (`tag_we` high while selected) updates the stored tag at `addr` only at a rising clock edge. Before that edge `tag_q` keeps showing the old value, and the stored status at that address is not changed.
- R2: A status write (`st_we` high while selected) stores `st_in` at `addr` on the rising edge and leaves the stored tag unchanged. Status bit 0 is valid, bit 1 is dirty, bit 2 is write-through.
- R3: `tag_q` and `st_q` show the stored fields at `addr` combinationally. `tag_q` reads zero when `tag_oe_n` is high or the block is deselected. `st_q` reads zero when `st_oe_n` is high or the block is deselected.
- R4: With `sfunc_user` low, `match` is high exactly when the block is selected, the stored tag at `addr` equals `tag_in`, and the stored valid bit is set.
- R5: With `sfunc_user` high, `match` follows tag equality while selected and ignores the stored valid bit.
- R6: When `clr_all_n` is low at a rising edge, every stored status field becomes zero. This takes priority over a status write in the same cycle and does not change any stored tag.
- R7: The block is selected only when `cs1_n` is low and `cs2` is high. While it is deselected, tag and status writes have no effect and `match` stays low.
- R8: `ta_n` is active low. It asserts on a hit when `rd_wr` is high (read). On a hit with `rd_wr` low (write), it asserts only if the stored write-through bit is clear, except in user mode (`sfunc_user` high), where any write hit asserts it.
- R9: `ta_force_hi` high holds `ta_n` high. Otherwise `ta_in_n` low asserts `ta_n` regardless of the hit. `ta_oe_n` high drives `ta_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes and the flush |
| clr_all_n | input | 1 | Active-low flush of all status fields, sampled on the clock edge |
| cs1_n | input | 1 | Active-low chip select |
| cs2 | input | 1 | Active-high chip select |
| addr | input | AW | Line address |
| tag_in | input | TW | Tag to write and to compare |
| tag_we | input | 1 | Tag field write enable |
| tag_oe_n | input | 1 | Active-low enable for tag read data |
| tag_q | output | TW | Stored tag at addr, or zero |
| st_in | input | 3 | Status to write (bit0 valid, bit1 dirty, bit2 write-through) |
| st_we | input | 1 | Status field write enable |
| st_oe_n | input | 1 | Active-low enable for status read data |
| st_q | output | 3 | Stored status at addr, or zero |
| sfunc_user | input | 1 | 0: fixed status meaning, 1: status is user storage |
| rd_wr | input | 1 | Bus direction, 1 for read, 0 for write |
| ta_in_n | input | 1 | Active-low external acknowledge |
| ta_force_hi | input | 1 | Forces ta_n deasserted |
| ta_oe_n | input | 1 | Active-low enable for ta_n |
| match | output | 1 | Qualified tag hit |
| ta_n | output | 1 | Active-low transfer acknowledge |

## Verification
The bench checks that a pending tag write stays invisible until its clock edge. A design that wrote through combinationally would show the new tag early. It flushes the array in the same cycle as a status write to the same line. Giving the write priority would leave that line valid, and letting the flush reach the tag field would lose the stored tag. It switches between the two status modes on an entry whose tag matches but whose valid bit is clear, which exposes a comparator that always or never uses the valid bit. It also drives write hits with the write-through bit set and clear, and in user mode, which exposes an acknowledge that ignores direction or mode.

// File: rtl/ctag_pkg.sv
package ctag_pkg;

    localparam int STAT_W = 3;

    // status field layout: bit0 valid, bit1 dirty, bit2 write-through
    typedef struct packed {
        logic wthru;
        logic dirty;
        logic valid;
    } stat_t;

    typedef enum logic {
        MODE_FIXED = 1'b0,
        MODE_USER  = 1'b1
    } stat_mode_e;

    typedef struct packed {
        logic       hit;
        logic       is_read;
        logic       wthru;
        stat_mode_e mode;
    } ack_ctx_t;

    // a hit acknowledges reads; writes only when write-through is off
    // or the status bits have no fixed meaning
    function automatic logic hit_acks(ack_ctx_t c);
        return c.hit && (c.is_read || (c.mode == MODE_USER) || !c.wthru);
    endfunction

endpackage

// File: rtl/ctag_tag_array.sv
module ctag_tag_array #(
    parameter int AW = 8,
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [TW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/ctag_stat_array.sv
module ctag_stat_array
    import ctag_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  stat_t         wdata,
    output stat_t         rdata
);
    localparam int DEPTH = 1 << AW;

    stat_t          st_r [DEPTH];
    logic [DEPTH-1:0] row_wr;

    // one-hot row decode for the write port
    for (genvar g = 0; g < DEPTH; g++) begin : g_dec
        assign row_wr[g] = we && (addr == AW'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!clr_n) begin
                st_r[i] <= '0;
            end else if (row_wr[i]) begin
                st_r[i] <= wdata;
            end
        end
    end

    assign rdata = st_r[addr];
endmodule

// File: rtl/ctag_cmp.sv
module ctag_cmp
    import ctag_pkg::*;
#(
    parameter int TW = 12
) (
    input  logic          sel,
    input  logic [TW-1:0] stored,
    input  logic [TW-1:0] probe,
    input  logic          valid,
    input  stat_mode_e    mode,
    output logic          hit
);
    logic eq;

    assign eq  = (stored == probe);
    assign hit = sel && eq && ((mode == MODE_USER) || valid);
endmodule

// File: rtl/ctag_ack.sv
module ctag_ack
    import ctag_pkg::*;
(
    input  logic       hit,
    input  logic       is_read,
    input  logic       wthru,
    input  stat_mode_e mode,
    input  logic       ext_n,
    input  logic       force_hi,
    input  logic       oe_n,
    output logic       ack_n
);
    ack_ctx_t ctx;
    logic     assert_ack;

    always_comb begin
        ctx.hit     = hit;
        ctx.is_read = is_read;
        ctx.wthru   = wthru;
        ctx.mode    = mode;
        assert_ack  = !force_hi && (!ext_n || hit_acks(ctx));
        ack_n       = oe_n ? 1'b1 : !assert_ack;
    end
endmodule

// File: rtl/ctag_store.sv
module ctag_store
    import ctag_pkg::*;
#(
    parameter int AW = 8,
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          clr_all_n,
    input  logic          cs1_n,
    input  logic          cs2,
    input  logic [AW-1:0] addr,
    input  logic [TW-1:0] tag_in,
    input  logic          tag_we,
    input  logic          tag_oe_n,
    output logic [TW-1:0] tag_q,
    input  logic [2:0]    st_in,
    input  logic          st_we,
    input  logic          st_oe_n,
    output logic [2:0]    st_q,
    input  logic          sfunc_user,
    input  logic          rd_wr,
    input  logic          ta_in_n,
    input  logic          ta_force_hi,
    input  logic          ta_oe_n,
    output logic          match,
    output logic          ta_n
);
    logic          sel;
    logic [TW-1:0] tag_rd;
    stat_t         st_rd;
    stat_t         st_wd;
    stat_mode_e    mode;

    assign sel   = !cs1_n && cs2;
    assign mode  = stat_mode_e'(sfunc_user);
    assign st_wd = stat_t'(st_in);

    ctag_tag_array #(.AW(AW), .TW(TW)) tag_arr_i (
        .clk   (clk),
        .we    (sel && tag_we),
        .addr  (addr),
        .wdata (tag_in),
        .rdata (tag_rd)
    );

    ctag_stat_array #(.AW(AW)) stat_arr_i (
        .clk   (clk),
        .clr_n (clr_all_n),
        .we    (sel && st_we),
        .addr  (addr),
        .wdata (st_wd),
        .rdata (st_rd)
    );

    ctag_cmp #(.TW(TW)) cmp_i (
        .sel    (sel),
        .stored (tag_rd),
        .probe  (tag_in),
        .valid  (st_rd.valid),
        .mode   (mode),
        .hit    (match)
    );

    ctag_ack ack_i (
        .hit      (match),
        .is_read  (rd_wr),
        .wthru    (st_rd.wthru),
        .mode     (mode),
        .ext_n    (ta_in_n),
        .force_hi (ta_force_hi),
        .oe_n     (ta_oe_n),
        .ack_n    (ta_n)
    );

    assign tag_q = (sel && !tag_oe_n) ? tag_rd : '0;
    assign st_q  = (sel && !st_oe_n) ? 3'(st_rd) : 3'b000;
endmodule

// File: rtl/ctag_store_chk.sv
module ctag_store_chk #(
    parameter int AW = 8,
    parameter int TW = 12
) (
    input logic          clk,
    input logic          clr_all_n,
    input logic          cs1_n,
    input logic          cs2,
    input logic [AW-1:0] addr,
    input logic          st_we,
    input logic          st_oe_n,
    input logic          tag_oe_n,
    input logic [TW-1:0] tag_q,
    input logic [2:0]    st_q,
    input logic [2:0]    st_raw,
    input logic          sfunc_user,
    input logic          ta_force_hi,
    input logic          ta_oe_n,
    input logic          match,
    input logic          ta_n
);
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (!clr_all_n) begin
            armed <= 1'b1;
        end
    end

    // R7
    match_needs_sel_chk: assert property (@(posedge clk) disable iff (!armed)
        match |-> (!cs1_n && cs2));

    // R4
    match_needs_valid_chk: assert property (@(posedge clk) disable iff (!armed)
        (match && !sfunc_user) |-> st_raw[0]);

    // R6
    flush_clears_chk: assert property (@(posedge clk) disable iff (!armed)
        !clr_all_n |=> ((!cs1_n && cs2 && !st_oe_n) -> (st_q == 3'b000)));

    // R2
    status_hold_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_all_n && !(st_we && !cs1_n && cs2)) |=> ($stable(addr) -> $stable(st_raw)));

    // R3
    tag_oe_chk: assert property (@(posedge clk) disable iff (!armed)
        tag_oe_n |-> (tag_q == '0));

    // R9
    ta_force_chk: assert property (@(posedge clk) disable iff (!armed)
        (ta_force_hi || ta_oe_n) |-> ta_n);
endmodule

bind ctag_store ctag_store_chk #(.AW(AW), .TW(TW)) chk_i (
    .clk         (clk),
    .clr_all_n   (clr_all_n),
    .cs1_n       (cs1_n),
    .cs2         (cs2),
    .addr        (addr),
    .st_we       (st_we),
    .st_oe_n     (st_oe_n),
    .tag_oe_n    (tag_oe_n),
    .tag_q       (tag_q),
    .st_q        (st_q),
    .st_raw      (st_rd),
    .sfunc_user  (sfunc_user),
    .ta_force_hi (ta_force_hi),
    .ta_oe_n     (ta_oe_n),
    .match       (match),
    .ta_n        (ta_n)
);

// File: tb/ctag_store_tb.sv
module ctag_store_tb_top;
    localparam int AW = 4;
    localparam int TW = 12;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          clr_all_n, cs1_n, cs2;
    logic [AW-1:0] addr;
    logic [TW-1:0] tag_in, tag_q;
    logic          tag_we, tag_oe_n;
    logic [2:0]    st_in, st_q;
    logic          st_we, st_oe_n;
    logic          sfunc_user, rd_wr, ta_in_n, ta_force_hi, ta_oe_n;
    logic          match, ta_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ctag_store #(.AW(AW), .TW(TW)) dut_i (
        .clk(clk), .clr_all_n(clr_all_n), .cs1_n(cs1_n), .cs2(cs2),
        .addr(addr), .tag_in(tag_in), .tag_we(tag_we), .tag_oe_n(tag_oe_n),
        .tag_q(tag_q), .st_in(st_in), .st_we(st_we), .st_oe_n(st_oe_n),
        .st_q(st_q), .sfunc_user(sfunc_user), .rd_wr(rd_wr),
        .ta_in_n(ta_in_n), .ta_force_hi(ta_force_hi), .ta_oe_n(ta_oe_n),
        .match(match), .ta_n(ta_n)
    );

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        clr_all_n = 1; cs1_n = 0; cs2 = 1; tag_we = 0; st_we = 0;
        tag_oe_n = 0; st_oe_n = 0; sfunc_user = 0; rd_wr = 1;
        ta_in_n = 1; ta_force_hi = 0; ta_oe_n = 0; st_in = '0;
    endtask

    task automatic wr_tag(int a, logic [TW-1:0] t);
        addr = AW'(a); tag_in = t; tag_we = 1; tick(); tag_we = 0;
    endtask

    task automatic wr_st(int a, logic [2:0] s);
        addr = AW'(a); st_in = s; st_we = 1; tick(); st_we = 0;
    endtask

    task automatic t_reset();
        idle(); addr = '0; tag_in = '0;
        clr_all_n = 0; tick(); clr_all_n = 1;
        addr = 4'd3; tag_in = 12'h000; #1;
        chk("R6 status after flush", st_q, 3'b000);
        chk("R4 no match when invalid", match, 1'b0);
        chk("R8 no ack on miss", ta_n, 1'b1);
    endtask

    task automatic t_tag_write();
        wr_tag(5, 12'h111);
        addr = 4'd5; tag_in = 12'hA5C; tag_we = 1; #1;
        chk("R1 tag before edge", tag_q, 12'h111);
        tick(); tag_we = 0; #1;
        chk("R1 tag after edge", tag_q, 12'hA5C);
        chk("R1 status untouched by tag write", st_q, 3'b000);
    endtask

    task automatic t_stat_write();
        tag_in = 12'h000;
        wr_st(5, 3'b101); #1;
        chk("R2 status stored", st_q, 3'b101);
        chk("R2 tag untouched by status write", tag_q, 12'hA5C);
    endtask

    task automatic t_match();
        addr = 4'd5; tag_in = 12'hA5C; #1;
        chk("R4 match on valid equal tag", match, 1'b1);
        tag_in = 12'hA5D; #1;
        chk("R4 no match on tag differ", match, 1'b0);
    endtask

    task automatic t_user_mode();
        wr_tag(6, 12'h123);
        addr = 4'd6; tag_in = 12'h123; sfunc_user = 0; #1;
        chk("R4 invalid entry no match", match, 1'b0);
        sfunc_user = 1; #1;
        chk("R5 user mode ignores valid", match, 1'b1);
        sfunc_user = 0;
    endtask

    task automatic t_oe_sel();
        addr = 4'd5; tag_in = 12'hA5C;
        tag_oe_n = 1; #1;
        chk("R3 tag output disabled", tag_q, 12'h000);
        chk("R3 status still visible", st_q, 3'b101);
        tag_oe_n = 0; st_oe_n = 1; #1;
        chk("R3 status output disabled", st_q, 3'b000);
        st_oe_n = 0; cs2 = 0; #1;
        chk("R7 deselected no match", match, 1'b0);
        chk("R3 deselected tag reads zero", tag_q, 12'h000);
        cs2 = 1;
    endtask

    task automatic t_desel_write();
        cs1_n = 1;
        wr_tag(5, 12'hFFF);
        wr_st(5, 3'b010);
        cs1_n = 0; addr = 4'd5; #1;
        chk("R7 deselected tag write ignored", tag_q, 12'hA5C);
        chk("R7 deselected status write ignored", st_q, 3'b101);
    endtask

    task automatic t_ack();
        addr = 4'd5; tag_in = 12'hA5C; rd_wr = 1; #1;
        chk("R8 read hit acks", ta_n, 1'b0);
        rd_wr = 0; #1;
        chk("R8 write hit with write-through no ack", ta_n, 1'b1);
        sfunc_user = 1; #1;
        chk("R8 user mode write hit acks", ta_n, 1'b0);
        sfunc_user = 0;
        tag_in = 12'h000;
        wr_st(5, 3'b001);
        tag_in = 12'hA5C; #1;
        chk("R8 write hit copy-back acks", ta_n, 1'b0);
        rd_wr = 1; tag_in = 12'hA5D; #1;
        chk("R8 read miss no ack", ta_n, 1'b1);
    endtask

    task automatic t_ack_ctl();
        addr = 4'd5; tag_in = 12'hA5C; rd_wr = 1;
        ta_force_hi = 1; #1;
        chk("R9 force high overrides hit", ta_n, 1'b1);
        ta_force_hi = 0; tag_in = 12'hA5D; ta_in_n = 0; #1;
        chk("R9 external ack on miss", ta_n, 1'b0);
        ta_in_n = 1; tag_in = 12'hA5C; ta_oe_n = 1; #1;
        chk("R9 ack output disabled", ta_n, 1'b1);
        ta_oe_n = 0;
    endtask

    task automatic t_flush();
        int bad;
        for (int i = 0; i < DEPTH; i++) wr_st(i, 3'b111);
        addr = 4'd9; #1;
        chk("R2 fill status", st_q, 3'b111);
        addr = 4'd5; st_in = 3'b111; st_we = 1; clr_all_n = 0;
        tick(); st_we = 0; clr_all_n = 1;
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            addr = AW'(i); #1;
            if (st_q != 3'b000) bad++;
        end
        chk("R6 all status cleared", bad, 0);
        addr = 4'd5; tag_in = 12'hA5C; #1;
        chk("R6 flush beats status write", st_q, 3'b000);
        chk("R6 tag kept through flush", tag_q, 12'hA5C);
        chk("R6 no match after flush", match, 1'b0);
    endtask

    initial begin
        idle(); addr = '0; tag_in = '0;
        tick();
        t_reset();
        t_tag_write();
        t_stat_write();
        t_match();
        t_user_mode();
        t_oe_sel();
        t_desel_write();
        t_ack();
        t_ack_ctl();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule